// File: doc/BRIEF.md
# Conditional Compare/Test Flag Unit

This block produces the arithmetic status flags for a conditional compare or a conditional test operation. A 4-bit source condition code is checked against the incoming status flags. If the check holds, the block subtracts the second operand from the first (compare) or ANDs the two operands (test) at the selected operand size, and it derives OF, SF, ZF, CF, PF and AF from that result. If the check fails, no arithmetic flags are used. Instead, a default flag vector carried in the instruction is loaded.

Two condition codes do not read the flags. Code 0b1010 is always true, which turns the operation into a plain compare or test. Code 0b1011 is always false, which loads the defaults without any condition. Because of this, the parity flag can never be tested by the predicate. An encoding with the ND bit set is not a legal form. The block flags it and leaves the status flags unchanged. Results are registered on a valid strobe and held between strobes. A false predicate does not suppress memory faults; faults are handled where the operand is fetched, outside this block.

Top module: `ccflag_unit`

## Requirements
- R1: While reset is asserted and after it is released (before any valid strobe), all six flag outputs and bad_enc_o are 0.
- R2: The flag vector cond_flags_i is ordered [3]=OF, [2]=SF, [1]=ZF, [0]=CF. The predicate follows the standard condition encoding, where bit 0 of the code inverts the base test. The base tests on scc_i[3:1] are:
  - 0: OF
  - 1: CF
  - 2: ZF
  - 3: CF|ZF
  - 4: SF
  - 6: SF^OF
  - 7: ZF|(SF^OF)
- R3: Code 4'hA is true and code 4'hB is false, for every value of cond_flags_i.
- R4: For a compare with a true predicate, the operand size is set by size_i (0=8, 1=16, 2=32, 3=64 bits) and only the low bits of each operand are used. The flags are:
  - CF: unsigned borrow of src1-src2.
  - OF: signed overflow of that subtraction.
  - SF: MSB of the result.
  - ZF: set when the result is zero.
- R5: With a true predicate, PF is 1 when the low byte of the result has an even number of ones. For a compare, AF is the borrow out of bit 3.
- R6: For a test (is_test_i=1) with a true predicate, the result is src1&src2 at the selected size. SF, ZF and PF follow that result, and OF, CF and AF are 0.
- R7: With a false predicate, dflt_i (ordered [3]=OF, [2]=SF, [1]=ZF, [0]=CF) loads OF, SF, ZF and CF. PF takes dflt_i[0] and AF is 0.
- R8: A valid strobe with nd_i=1 sets bad_enc_o to 1 and leaves all six flags unchanged. A valid strobe with nd_i=0 clears bad_enc_o.
- R9: Outputs change only on the clock edge where valid_i is 1, and are visible from the cycle after that edge. Without valid_i all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| cond_flags_i | input | 4 | Incoming OF, SF, ZF, CF |
| scc_i | input | 4 | Source condition code |
| is_test_i | input | 1 | 1 = test (AND), 0 = compare (subtract) |
| size_i | input | 2 | Operand size select |
| src1_i | input | DATA_W | First operand |
| src2_i | input | DATA_W | Second operand |
| dflt_i | input | 4 | Default OF, SF, ZF, CF |
| nd_i | input | 1 | ND encoding bit, must be 0 |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| pf_o | output | 1 | Parity flag |
| af_o | output | 1 | Auxiliary carry flag |
| bad_enc_o | output | 1 | ND was set on the last strobe |

## Verification
The assertions take for granted that every input is stable and known on each edge where valid_i is high. They also assume the predicate wire brought out of the top reflects only scc_i and cond_flags_i. The bench drives inputs only on falling edges and holds them for one full cycle. It samples outputs on the next falling edge, so each strobe lands in exactly one rising edge. It exercises all 16 codes against all 16 flag patterns, and covers every operand size with boundary values (equal operands, sign-crossing and zero-crossing) as well as pseudo-random data.

// File: rtl/ccflag_pkg.sv
package ccflag_pkg;

  typedef enum logic [1:0] {
    SZ8  = 2'd0,
    SZ16 = 2'd1,
    SZ32 = 2'd2,
    SZ64 = 2'd3
  } opsize_e;

  localparam int NUM_SIZES = 4;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic cf_f;
    logic pf_f;
    logic af_f;
  } flagset_t;

  // even number of ones in a byte
  function automatic logic lowbyte_even(input logic [7:0] b);
    return ~(^b);
  endfunction

  // default-vector substitution on a false predicate
  function automatic flagset_t from_default(input logic [3:0] d);
    return flagset_t'({d[3], d[2], d[1], d[0], d[0], 1'b0});
  endfunction

endpackage

// File: rtl/ccflag_pred.sv
module ccflag_pred (
  input  logic [3:0] scc,
  input  logic [3:0] flg,   // [3]=OF [2]=SF [1]=ZF [0]=CF
  output logic       take
);
  logic f_of, f_sf, f_zf, f_cf, lt;
  logic base;

  assign f_of = flg[3];
  assign f_sf = flg[2];
  assign f_zf = flg[1];
  assign f_cf = flg[0];
  assign lt   = f_sf ^ f_of;

  always_comb begin
    unique case (scc[3:1])
      3'd0: base = f_of;
      3'd1: base = f_cf;
      3'd2: base = f_zf;
      3'd3: base = f_cf | f_zf;
      3'd4: base = f_sf;
      3'd5: base = 1'b1;          // constant pair: A true, B false
      3'd6: base = lt;
      default: base = f_zf | lt;
    endcase
  end

  assign take = base ^ scc[0];
endmodule

// File: rtl/ccflag_alu.sv
module ccflag_alu
  import ccflag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              is_test,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output flagset_t          flg
);
  flagset_t per_size [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_sz
    localparam int W = 8 << g;
    logic [W-1:0] a_w, b_w, r_and, r_sub;
    logic [W:0]   diff;
    logic         ov;

    assign a_w   = a[W-1:0];
    assign b_w   = b[W-1:0];
    assign diff  = {1'b0, a_w} - {1'b0, b_w};
    assign r_sub = diff[W-1:0];
    assign r_and = a_w & b_w;
    assign ov    = (a_w[W-1] ^ b_w[W-1]) & (a_w[W-1] ^ r_sub[W-1]);

    assign per_size[g] = is_test
      ? flagset_t'({1'b0, r_and[W-1], (r_and == '0), 1'b0,
                    lowbyte_even(r_and[7:0]), 1'b0})
      : flagset_t'({ov, r_sub[W-1], (r_sub == '0), diff[W],
                    lowbyte_even(r_sub[7:0]), a_w[4] ^ b_w[4] ^ r_sub[4]});
  end

  assign flg = per_size[size];
endmodule

// File: rtl/ccflag_unit.sv
module ccflag_unit
  import ccflag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [3:0]        cond_flags_i,
  input  logic [3:0]        scc_i,
  input  logic              is_test_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [3:0]        dflt_i,
  input  logic              nd_i,
  output logic              of_o,
  output logic              sf_o,
  output logic              zf_o,
  output logic              cf_o,
  output logic              pf_o,
  output logic              af_o,
  output logic              bad_enc_o
);
  logic     pred_true;
  logic     commit;
  flagset_t alu_f, next_f, flag_q;
  logic     bad_q;

  ccflag_pred u_pred (
    .scc  (scc_i),
    .flg  (cond_flags_i),
    .take (pred_true)
  );

  ccflag_alu #(.DATA_W(DATA_W)) u_alu (
    .is_test (is_test_i),
    .size    (size_i),
    .a       (src1_i),
    .b       (src2_i),
    .flg     (alu_f)
  );

  assign commit = valid_i & ~nd_i;
  assign next_f = pred_true ? alu_f : from_default(dflt_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      if (valid_i) bad_q  <= nd_i;
      if (commit)  flag_q <= next_f;
    end
  end

  assign of_o      = flag_q.of_f;
  assign sf_o      = flag_q.sf_f;
  assign zf_o      = flag_q.zf_f;
  assign cf_o      = flag_q.cf_f;
  assign pf_o      = flag_q.pf_f;
  assign af_o      = flag_q.af_f;
  assign bad_enc_o = bad_q;
endmodule

// File: rtl/ccflag_chk.sv
module ccflag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       valid_i,
  input logic       nd_i,
  input logic       is_test_i,
  input logic [3:0] scc_i,
  input logic [3:0] dflt_i,
  input logic       pred_true,
  input logic       of_o,
  input logic       sf_o,
  input logic       zf_o,
  input logic       cf_o,
  input logic       pf_o,
  input logic       af_o,
  input logic       bad_enc_o
);
  logic [6:0] outs;
  assign outs = {of_o, sf_o, zf_o, cf_o, pf_o, af_o, bad_enc_o};

  assert_always_true_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scc_i == 4'hA) |-> pred_true);

  assert_always_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (scc_i == 4'hB) |-> !pred_true);

  assert_default_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !nd_i && !pred_true) |=>
      ({of_o, sf_o, zf_o, cf_o} == $past(dflt_i)) && (pf_o == $past(dflt_i[0])) && !af_o);

  assert_test_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !nd_i && pred_true && is_test_i) |=> (!of_o && !cf_o && !af_o));

  assert_bad_nd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && nd_i) |=> (bad_enc_o && (outs[6:1] == $past(outs[6:1]))));

  assert_good_nd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !nd_i) |=> !bad_enc_o);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(outs));
endmodule

bind ccflag_unit ccflag_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .nd_i      (nd_i),
  .is_test_i (is_test_i),
  .scc_i     (scc_i),
  .dflt_i    (dflt_i),
  .pred_true (pred_true),
  .of_o      (of_o),
  .sf_o      (sf_o),
  .zf_o      (zf_o),
  .cf_o      (cf_o),
  .pf_o      (pf_o),
  .af_o      (af_o),
  .bad_enc_o (bad_enc_o)
);

// File: tb/test_ccflag_unit.sv
`timescale 1ns/1ps
module test_ccflag_unit;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid_i = 1'b0;
  logic [3:0]    cond_flags_i = '0, scc_i = '0, dflt_i = '0;
  logic          is_test_i = 1'b0, nd_i = 1'b0;
  logic [1:0]    size_i = '0;
  logic [DW-1:0] src1_i = '0, src2_i = '0;
  logic of_o, sf_o, zf_o, cf_o, pf_o, af_o, bad_enc_o;

  int n_checks = 0;
  int n_fails  = 0;
  logic [6:0] exp_q = '0;   // {of,sf,zf,cf,pf,af,bad}
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  ccflag_unit #(.DATA_W(DW)) i_ccflag_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cond_flags_i(cond_flags_i),
    .scc_i(scc_i), .is_test_i(is_test_i), .size_i(size_i), .src1_i(src1_i),
    .src2_i(src2_i), .dflt_i(dflt_i), .nd_i(nd_i),
    .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o), .cf_o(cf_o), .pf_o(pf_o),
    .af_o(af_o), .bad_enc_o(bad_enc_o)
  );

  function automatic logic [63:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic bit eval_cc(input logic [3:0] f, input logic [3:0] cc);
    bit o = f[3], s = f[2], z = f[1], c = f[0];
    case (cc)
      4'h0: return o;        4'h1: return !o;
      4'h2: return c;        4'h3: return !c;
      4'h4: return z;        4'h5: return !z;
      4'h6: return c || z;   4'h7: return !(c || z);
      4'h8: return s;        4'h9: return !s;
      4'hA: return 1'b1;     4'hB: return 1'b0;
      4'hC: return s != o;   4'hD: return s == o;
      4'hE: return z || (s != o);
      default: return !z && (s == o);
    endcase
  endfunction

  function automatic logic [5:0] model(input logic [3:0] f, input logic [3:0] cc,
      input bit tst, input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b,
      input logic [3:0] d);
    int w = 8 << sz;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] am = a & mask, bm = b & mask, r;
    bit o, s, z, c, p, x, sa, sb, sr;
    if (!eval_cc(f, cc)) return {d[3], d[2], d[1], d[0], d[0], 1'b0};
    if (tst) begin
      r = am & bm; o = 0; c = 0; x = 0;
    end else begin
      r  = (am - bm) & mask;
      c  = am < bm;
      sa = am[w-1]; sb = bm[w-1]; sr = r[w-1];
      o  = (sa != sb) && (sr != sa);
      x  = (am & 64'hF) < (bm & 64'hF);
    end
    s = r[w-1];
    z = (r == 0);
    p = ($countones(r[7:0]) % 2) == 0;
    return {o, s, z, c, p, x};
  endfunction

  task automatic check(input string tag, input logic [6:0] exp);
    logic [6:0] act = {of_o, sf_o, zf_o, cf_o, pf_o, af_o, bad_enc_o};
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b (of sf zf cf pf af bad)", tag, act, exp);
    end
  endtask

  // one strobe, sampled one full cycle later on a falling edge
  task automatic strobe(input string tag, input logic [3:0] f, input logic [3:0] cc,
      input bit tst, input logic [1:0] sz, input logic [63:0] a, input logic [63:0] b,
      input logic [3:0] d, input bit nd);
    cond_flags_i = f; scc_i = cc; is_test_i = tst; size_i = sz;
    src1_i = a; src2_i = b; dflt_i = d; nd_i = nd; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    if (nd) exp_q = {exp_q[6:1], 1'b1};
    else    exp_q = {model(f, cc, tst, sz, a, b, d), 1'b0};
    check(tag, exp_q);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", 7'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 7'b0);
    exp_q = '0;
  endtask

  task automatic t_cond_sweep();
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++)
        strobe((cc == 10 || cc == 11) ? "R3 constant code" : "R2 predicate sweep",
               4'(f), 4'(cc), 1'b0, 2'd0, 64'h12, 64'h34, 4'(~f), 1'b0);
  endtask

  task automatic t_cmp_edges();
    strobe("R4 8b equal",        4'h0, 4'hA, 0, 2'd0, 64'h55, 64'h55, 4'h0, 0);
    strobe("R4 8b borrow",       4'h0, 4'hA, 0, 2'd0, 64'h01, 64'h02, 4'h0, 0);
    strobe("R4 8b overflow",     4'h0, 4'hA, 0, 2'd0, 64'h80, 64'h01, 4'h0, 0);
    strobe("R4 16b overflow",    4'h0, 4'hA, 0, 2'd1, 64'hFF_7FFF, 64'h8000, 4'h0, 0);
    strobe("R4 32b upper ignored", 4'h0, 4'hA, 0, 2'd2, 64'hAAAA_0000_0010, 64'h10, 4'h0, 0);
    strobe("R4 64b sign cross",  4'h0, 4'hA, 0, 2'd3, 64'h8000_0000_0000_0000, 64'd1, 4'h0, 0);
    strobe("R5 af borrow bit3",  4'h0, 4'hA, 0, 2'd0, 64'h10, 64'h01, 4'h0, 0);
    strobe("R5 parity odd",      4'h0, 4'hA, 0, 2'd3, 64'h7, 64'h0, 4'h0, 0);
    for (int i = 0; i < 40; i++)
      strobe("R4 R5 random cmp", 4'h0, 4'hA, 0, 2'(i), next_rand(), next_rand(), 4'h0, 0);
  endtask

  task automatic t_test_ops();
    strobe("R6 test zero",   4'h0, 4'hA, 1, 2'd0, 64'hF0, 64'h0F, 4'hF, 0);
    strobe("R6 test sign64", 4'h0, 4'hA, 1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0003, 4'hF, 0);
    for (int i = 0; i < 20; i++)
      strobe("R6 random test", 4'h0, 4'hA, 1, 2'(i), next_rand(), next_rand(), 4'hF, 0);
  endtask

  task automatic t_defaults();
    strobe("R7 defaults 1001", 4'h0, 4'hB, 0, 2'd3, 64'h5, 64'h3, 4'b1001, 0);
    strobe("R7 defaults 0110", 4'h0, 4'hB, 1, 2'd0, 64'hFF, 64'hFF, 4'b0110, 0);
    strobe("R7 false ZF code", 4'b0000, 4'h4, 0, 2'd0, 64'h1, 64'h1, 4'b1111, 0);
  endtask

  task automatic t_nd();
    strobe("R8 nd flags kept", 4'h0, 4'hA, 0, 2'd0, 64'h00, 64'h01, 4'h0, 0);
    strobe("R8 nd set",        4'h0, 4'hB, 0, 2'd0, 64'h7, 64'h7, 4'h0, 1);
    strobe("R8 nd cleared",    4'h0, 4'hA, 0, 2'd0, 64'h7, 64'h7, 4'h0, 0);
  endtask

  task automatic t_hold();
    strobe("R9 setup", 4'h0, 4'hA, 0, 2'd0, 64'h80, 64'h01, 4'h0, 0);
    for (int i = 0; i < 4; i++) begin
      cond_flags_i = 4'(next_rand()); scc_i = 4'hB; dflt_i = 4'(next_rand());
      src1_i = next_rand(); src2_i = next_rand(); nd_i = 1'(i);
      @(negedge clk);
      check("R9 hold without valid", exp_q);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_cond_sweep();
    t_cmp_edges();
    t_test_ops();
    t_defaults();
    t_nd();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule